// File: doc/BRIEF.md
# Mixed-Policy Direct-Mapped Data Cache Controller

The block is a direct-mapped data cache that sits between a processor load/store port and a word-wide memory port. Each line holds 16 bytes, as four 32-bit words, plus a tag, a valid flag and a dirty flag. The write policy is chosen for each access by the region-mode input `cpu_wt`. When it is 1, the access is write-through and a write miss does not allocate a line. When it is 0, the access is copyback with write-allocate. A write that misses in a copyback region first fills the whole line from memory. Only then is the write merged into the line and the line marked dirty. Write data never lands in an invalid line.

Both ports use a valid/ready handshake, and both are subject to back-pressure.
- **Processor port.** The processor raises `cpu_valid` and holds the address, data, size, direction and mode steady until it sees `cpu_ready` high. The access completes in the cycle where both are high. On a read, `cpu_rdata` is valid in that same cycle. While a line is pushed out, filled or written through, `cpu_ready` stays low.
- **Memory port.** The controller raises `mem_req` and holds `mem_we`, `mem_addr`, `mem_be` and `mem_wdata` steady until `mem_ready`. One word moves in each cycle where both are high. For a read, `mem_rdata` must be valid in that cycle.

Pulsing `inval_all` while the controller is idle invalidates every line and writes nothing back.

Top module: `mixcache_ctrl`

## Requirements
- R1: After reset every line is invalid. With `cpu_valid` low, `cpu_ready` and `mem_req` are both low.
- R2: A read that hits completes in the same cycle `cpu_valid` is seen. It returns the cached word, makes no memory request and leaves the line's flags unchanged.
- R3: A read miss in either mode reads the four line words from memory in ascending offset order (0x0, 0x4, 0x8, 0xC) with `mem_we`=0. It then returns the requested word and leaves the line valid and clean.
- R4: A write miss in copyback mode (`cpu_wt`=0) fills the line first, exactly as in R3. It then merges the write and leaves the line valid and dirty, with no memory write for the store itself.
- R5: A write hit in copyback mode updates only the addressed bytes, marks the line dirty and issues no memory transfer.
- R6: A write miss in write-through mode (`cpu_wt`=1) issues a single memory write of the word-aligned address. It allocates and fills no line.
- R7: A write hit in write-through mode issues a single memory write, updates the addressed bytes of the line and leaves the line's dirty flag unchanged.
- R8: Before a miss refills a line whose victim is valid and dirty, the four victim words are written to the victim's address in ascending offset order with `mem_be`=4'b1111.
- R9: A miss whose victim is invalid or clean writes nothing back.
- R10: A read hit on a dirty line never writes it back, even when the access carries the other region mode.
- R11: `inval_all`, sampled while idle, clears every valid and dirty flag without any memory write. Modified data held only in the cache is lost.
- R12: Access size is set by `cpu_size`: 0 for a byte, 1 for a halfword, 2 or 3 for a word. `cpu_wdata` is lane-aligned, with byte k on bits 8k+7:8k. Byte enables are:
  - byte: one-hot at `cpu_addr[1:0]`;
  - halfword: 4'b0011, or 4'b1100 when `cpu_addr[1]`=1;
  - word: 4'b1111.
- R13: `cpu_ready` is never high without `cpu_valid`. While `mem_req` is high and `mem_ready` low, the request and its address and direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inval_all | input | 1 | Invalidate-all command, sampled while idle |
| cpu_valid | input | 1 | Processor access request |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_wt | input | 1 | Region mode: 1 = write-through, 0 = copyback |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Lane-aligned store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` on a read |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Byte enables for a memory write |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts or returns a word this cycle |
| mem_rdata | input | 32 | Memory read data |

## Verification
Most faults in the flags or the tag show up at the memory port within one access:
- **Lost dirty flag.** A refill goes ahead with no four-word push. Under a directed access pattern this is visible within about five cycles of the miss.
- **Dirty flag set too eagerly.** A clean line is pushed when it is replaced.
- **Stale valid flag.** A read completes in the request cycle where the reference expects four fill reads.

Corrupted line data surfaces as a wrong `cpu_rdata` on the next read of that word. If the corruption is in dirty data, it surfaces instead as a wrong write-back word. A scoreboard with a reference cache and memory model compares every memory transfer and every load result. A long pseudo-random phase with random memory stalls hits victim conflicts often enough to surface faults that only appear after several accesses.

// File: rtl/mixcache_pkg.sv
package mixcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_FILL = 2'd2,
    ST_WT   = 2'd3
  } seq_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // byte-lane enables for a 32-bit word from access size and address low bits
  function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] low);
    logic [3:0] m;
    case (size)
      SZ_BYTE: m = 4'b0001 << low;
      SZ_HALF: m = low[1] ? 4'b1100 : 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/mixcache_lines.sv
module mixcache_lines #(
  parameter int SETS  = 8,
  parameter int WORDS = 4,
  parameter int TAG_W = 25,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFS_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inval_all,
  input  logic [IDX_W-1:0] idx,
  input  logic [OFS_W-1:0] rd_sel,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_v,
  output logic             rd_m,
  output logic [31:0]      rd_word,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_sel,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data,
  input  logic             fill_done,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_dirty
);

  logic [TAG_W-1:0] tag_q [SETS];
  logic [SETS-1:0]  v_q, m_q;
  logic [31:0]      data_q [SETS*WORDS];

  assign rd_tag  = tag_q[idx];
  assign rd_v    = v_q[idx];
  assign rd_m    = m_q[idx];
  assign rd_word = data_q[{idx, rd_sel}];

  always_ff @(posedge clk) begin
    if (!rst_n || inval_all) begin
      v_q <= '0;
      m_q <= '0;
    end else begin
      if (fill_done) begin
        v_q[idx] <= 1'b1;
        m_q[idx] <= 1'b0;
      end
      if (mark_dirty) m_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) tag_q[idx] <= fill_tag;
    if (wr_en) begin
      for (int b = 0; b < 4; b++) begin
        if (wr_be[b]) data_q[{idx, wr_sel}][8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
  end

  // a dirty line is always a valid line (R4)
  for (genvar s = 0; s < SETS; s++) begin : g_flag_chk
    p_dirty_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      m_q[s] |-> v_q[s])
      else $error("dirty flag on invalid line %0d", s);
  end

  p_inval_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> (v_q == '0) && (m_q == '0))
    else $error("invalidate-all left flags set");

endmodule

// File: rtl/mixcache_seq.sv
module mixcache_seq
  import mixcache_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inval_all,
  input  logic             cpu_valid,
  input  logic             cpu_write,
  input  logic             cpu_wt,
  input  logic             hit,
  input  logic             vic_dirty,
  input  logic             mem_ready,
  output seq_t             state,
  output logic [OFS_W-1:0] cnt,
  output logic             cpu_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic             fill_wr,
  output logic             fill_done,
  output logic             cb_merge,
  output logic             wt_merge,
  output logic             inval_go
);

  localparam logic [OFS_W-1:0] LAST = '1;

  seq_t nxt;

  always_comb begin
    nxt       = state;
    cpu_ready = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    fill_wr   = 1'b0;
    fill_done = 1'b0;
    cb_merge  = 1'b0;
    wt_merge  = 1'b0;
    inval_go  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (inval_all) begin
          inval_go = 1'b1;
        end else if (cpu_valid) begin
          if (cpu_write && cpu_wt) begin
            nxt = ST_WT;
          end else if (hit) begin
            cpu_ready = 1'b1;
            cb_merge  = cpu_write;
          end else begin
            nxt = vic_dirty ? ST_PUSH : ST_FILL;
          end
        end
      end
      ST_PUSH: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ready && cnt == LAST) nxt = ST_FILL;
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ready) begin
          fill_wr = 1'b1;
          if (cnt == LAST) begin
            fill_done = 1'b1;
            nxt       = ST_IDLE;
          end
        end
      end
      default: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ready) begin
          cpu_ready = 1'b1;
          wt_merge  = hit;
          nxt       = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (mem_ready && (state == ST_PUSH || state == ST_FILL)) cnt <= cnt + 1'b1;
    end
  end

  p_cnt_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_WT) |-> cnt == '0)
    else $error("word counter not at zero outside a line transfer");

  p_push_then_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PUSH && mem_ready && cnt == LAST) |=> state == ST_FILL)
    else $error("write-back not followed by refill");

  p_ready_needs_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid)
    else $error("cpu_ready without a request");

endmodule

// File: rtl/mixcache_ctrl.sv
module mixcache_ctrl
  import mixcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 8,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inval_all,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic              cpu_wt,
  input  logic [1:0]        cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata
);

  localparam int IDX_W = $clog2(SETS);
  localparam int OFS_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W - 2;

  logic [OFS_W-1:0] a_sel, rd_sel, wr_sel, cnt;
  logic [IDX_W-1:0] a_idx;
  logic [TAG_W-1:0] a_tag, rd_tag;
  logic [3:0]       lanes, wr_be;
  logic [31:0]      rd_word, wr_data;
  logic             rd_v, rd_m, hit, vic_dirty, wr_en;
  logic             fill_wr, fill_done, cb_merge, wt_merge, inval_go;
  seq_t             state;

  assign a_sel     = cpu_addr[OFS_W+1:2];
  assign a_idx     = cpu_addr[OFS_W+2 +: IDX_W];
  assign a_tag     = cpu_addr[ADDR_W-1 -: TAG_W];
  assign lanes     = lane_mask(cpu_size, cpu_addr[1:0]);
  assign hit       = rd_v && (rd_tag == a_tag);
  assign vic_dirty = rd_v && rd_m;

  assign rd_sel  = (state == ST_PUSH) ? cnt : a_sel;
  assign wr_en   = fill_wr | cb_merge | wt_merge;
  assign wr_sel  = fill_wr ? cnt : a_sel;
  assign wr_be   = fill_wr ? 4'hF : lanes;
  assign wr_data = fill_wr ? mem_rdata : cpu_wdata;

  always_comb begin
    case (state)
      ST_PUSH: mem_addr = {rd_tag, a_idx, cnt, 2'b00};
      ST_FILL: mem_addr = {a_tag, a_idx, cnt, 2'b00};
      default: mem_addr = {cpu_addr[ADDR_W-1:2], 2'b00};
    endcase
  end

  assign mem_be    = (state == ST_WT) ? lanes : 4'hF;
  assign mem_wdata = (state == ST_WT) ? cpu_wdata : rd_word;
  assign cpu_rdata = rd_word;

  mixcache_seq #(.OFS_W(OFS_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .inval_all (inval_all),
    .cpu_valid (cpu_valid),
    .cpu_write (cpu_write),
    .cpu_wt    (cpu_wt),
    .hit       (hit),
    .vic_dirty (vic_dirty),
    .mem_ready (mem_ready),
    .state     (state),
    .cnt       (cnt),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .fill_wr   (fill_wr),
    .fill_done (fill_done),
    .cb_merge  (cb_merge),
    .wt_merge  (wt_merge),
    .inval_go  (inval_go)
  );

  mixcache_lines #(.SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W)) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .inval_all  (inval_go),
    .idx        (a_idx),
    .rd_sel     (rd_sel),
    .rd_tag     (rd_tag),
    .rd_v       (rd_v),
    .rd_m       (rd_m),
    .rd_word    (rd_word),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_be      (wr_be),
    .wr_data    (wr_data),
    .fill_done  (fill_done),
    .fill_tag   (a_tag),
    .mark_dirty (cb_merge)
  );

  p_read_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !inval_all && cpu_valid && !cpu_write && hit) |-> cpu_ready && !mem_req)
    else $error("read hit stalled or touched memory");

  p_cb_hit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !inval_all && cpu_valid && cpu_write && !cpu_wt && hit) |=> !mem_req)
    else $error("copyback write hit caused memory traffic");

  p_fill_is_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL) |-> mem_req && !mem_we)
    else $error("fill issued a write");

  p_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PUSH) |-> mem_we && mem_be == 4'hF)
    else $error("write-back not a full-word write");

  p_mem_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_we))
    else $error("memory request changed while stalled");

endmodule

// File: tb/mixcache_ctrl_test.sv
module mixcache_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        inval_all;
  logic        cpu_valid, cpu_write, cpu_wt;
  logic [1:0]  cpu_size;
  logic [31:0] cpu_addr, cpu_wdata;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  always #2.5 clk = ~clk;

  mixcache_ctrl uut (
    .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
    .cpu_wt(cpu_wt), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // memory: real backing store and reference copy
  logic [31:0] memarr [256];
  logic [31:0] refmem [256];
  assign mem_rdata = memarr[mem_addr[9:2]];

  // reference cache
  bit          rv [8];
  bit          rm [8];
  logic [24:0] rtag [8];
  logic [31:0] rdat [8][4];

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
  } mx_t;

  mx_t         exp_mem [$];
  string       exp_mem_tag [$];
  logic [31:0] exp_rd [$];
  string       exp_rd_tag [$];
  string       cur_tag = "R1";
  bit          after_inval = 0;
  bit          stall_on = 0;

  function automatic logic [3:0] bmask(input logic [1:0] sz, input logic [1:0] lo);
    if (sz == 2'd0) return 4'b0001 << lo;
    if (sz == 2'd1) return lo[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  task automatic predict(input bit wr, input bit wt, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] wd);
    int          ix = int'(a[6:4]);
    int          ws = int'(a[3:2]);
    logic [24:0] tg = a[31:7];
    bit          hit = rv[ix] && rtag[ix] == tg;
    logic [3:0]  be = bmask(sz, a[1:0]);
    mx_t         it;
    string       ftag;
    if (wr && wt) begin
      cur_tag = hit ? "R7" : "R6";
      it = '{we: 1'b1, addr: {a[31:2], 2'b00}, be: be, data: wd};
      exp_mem.push_back(it); exp_mem_tag.push_back(cur_tag);
      refmem[a[9:2]] = merge(refmem[a[9:2]], wd, be);
      if (hit) rdat[ix][ws] = merge(rdat[ix][ws], wd, be);
    end else begin
      if (!hit) begin
        ftag = after_inval ? "R11" : (rv[ix] && !rm[ix]) ? "R9" : wr ? "R4" : "R3";
        cur_tag = ftag;
        if (rv[ix] && rm[ix]) begin
          for (int k = 0; k < 4; k++) begin
            it = '{we: 1'b1, addr: {rtag[ix], 3'(ix), 2'(k), 2'b00}, be: 4'hF, data: rdat[ix][k]};
            exp_mem.push_back(it); exp_mem_tag.push_back("R8");
            refmem[{rtag[ix][2:0], 3'(ix), 2'(k)}] = rdat[ix][k];
          end
        end
        for (int k = 0; k < 4; k++) begin
          it = '{we: 1'b0, addr: {tg, 3'(ix), 2'(k), 2'b00}, be: 4'hF, data: 32'h0};
          exp_mem.push_back(it); exp_mem_tag.push_back(ftag);
          rdat[ix][k] = refmem[{tg[2:0], 3'(ix), 2'(k)}];
        end
        rv[ix] = 1; rm[ix] = 0; rtag[ix] = tg;
      end else begin
        cur_tag = wr ? "R5" : (rm[ix] ? "R10" : "R2");
      end
      if (wr) begin
        rdat[ix][ws] = merge(rdat[ix][ws], wd, be);
        rm[ix] = 1;
      end else begin
        exp_rd.push_back(rdat[ix][ws]); exp_rd_tag.push_back(cur_tag);
      end
    end
    after_inval = 0;
  endtask

  // driver
  task automatic access(input bit wr, input bit wt, input logic [1:0] sz,
                        input logic [31:0] a, input logic [31:0] wd);
    bit got;
    predict(wr, wt, sz, a, wd);
    @(negedge clk);
    cpu_valid = 1; cpu_write = wr; cpu_wt = wt; cpu_size = sz;
    cpu_addr = a; cpu_wdata = wd;
    do begin
      #1 got = cpu_ready;
      if (!got) @(negedge clk);
    end while (!got);
    @(negedge clk);
    cpu_valid = 0;
    chk(exp_mem.size() == 0, cur_tag, "missing memory transfers", 32'(exp_mem.size()), 32'd0);
    exp_mem.delete(); exp_mem_tag.delete();
  endtask

  task automatic do_inval();
    @(negedge clk);
    inval_all = 1;
    @(negedge clk);
    inval_all = 0;
    for (int s = 0; s < 8; s++) begin rv[s] = 0; rm[s] = 0; end
    after_inval = 1;
  endtask

  // monitor: processor side
  always @(negedge clk) begin
    #1;
    if (rst_n === 1'b1) begin
      if (cpu_ready === 1'b1 && cpu_valid !== 1'b1)
        chk(0, "R13", "cpu_ready without cpu_valid", 32'(cpu_ready), 32'd0);
      if (cpu_valid && cpu_ready && !cpu_write) begin
        if (exp_rd.size() == 0) begin
          chk(0, cur_tag, "unexpected read completion", cpu_rdata, 32'h0);
        end else begin
          chk(cpu_rdata === exp_rd[0], exp_rd_tag[0], "read data", cpu_rdata, exp_rd[0]);
          void'(exp_rd.pop_front()); void'(exp_rd_tag.pop_front());
        end
      end
    end
  end

  // memory model and monitor
  logic [31:0] mlfsr = 32'h1234_5678;
  bit          prev_stall = 0;
  logic [31:0] prev_addr;
  logic        prev_we;
  always @(negedge clk) begin
    mlfsr = {mlfsr[30:0], mlfsr[31] ^ mlfsr[21] ^ mlfsr[1] ^ mlfsr[0]};
    mem_ready = stall_on ? (mlfsr[2:0] > 3'd2) : 1'b1;
    #1;
    if (rst_n === 1'b1) begin
      if (prev_stall)
        chk(mem_req === 1'b1 && mem_addr === prev_addr && mem_we === prev_we,
            "R13", "stalled request changed", mem_addr, prev_addr);
      prev_stall = mem_req && !mem_ready;
      prev_addr  = mem_addr;
      prev_we    = mem_we;
      if (mem_req && mem_ready) begin
        if (exp_mem.size() == 0) begin
          chk(0, cur_tag, "unexpected memory transfer", mem_addr, 32'h0);
        end else begin
          chk(mem_we === exp_mem[0].we, exp_mem_tag[0], "memory direction",
              32'(mem_we), 32'(exp_mem[0].we));
          chk(mem_addr === exp_mem[0].addr, exp_mem_tag[0], "memory address",
              mem_addr, exp_mem[0].addr);
          if (exp_mem[0].we) begin
            chk(mem_be === exp_mem[0].be, {exp_mem_tag[0], " R12"}, "byte enables",
                32'(mem_be), 32'(exp_mem[0].be));
            chk(mem_wdata === exp_mem[0].data, exp_mem_tag[0], "write data",
                mem_wdata, exp_mem[0].data);
          end
          void'(exp_mem.pop_front()); void'(exp_mem_tag.pop_front());
        end
        if (mem_we) memarr[mem_addr[9:2]] = merge(memarr[mem_addr[9:2]], mem_wdata, mem_be);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "R1", "watchdog expired", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 256; i++) begin
      memarr[i] = (32'(i) * 32'h0101_0101) ^ 32'hA5C3_0000;
      refmem[i] = memarr[i];
    end
    rst_n = 0; inval_all = 0; cpu_valid = 0; cpu_write = 0; cpu_wt = 0;
    cpu_size = 2'd2; cpu_addr = 0; cpu_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(cpu_ready === 1'b0, "R1", "cpu_ready after reset", 32'(cpu_ready), 32'd0);
    chk(mem_req === 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'd0);

    access(0, 0, 2'd2, 32'h010, 0);               // R3 read miss
    access(0, 0, 2'd2, 32'h014, 0);               // R2 read hit
    access(1, 0, 2'd0, 32'h00B, 32'h5A00_0000);   // R4 copyback write miss, byte lane 3
    access(0, 0, 2'd2, 32'h008, 0);
    access(1, 0, 2'd1, 32'h00E, 32'hBEEF_0000);   // R5 copyback hit, upper half
    access(0, 0, 2'd2, 32'h00C, 0);
    access(1, 1, 2'd2, 32'h104, 32'h1111_2222);   // R6 write-through miss
    access(0, 0, 2'd2, 32'h104, 0);               // R8 dirty victim push then fill
    access(1, 1, 2'd0, 32'h101, 32'h0000_7700);   // R7 write-through hit
    access(0, 0, 2'd2, 32'h100, 0);
    access(0, 0, 2'd2, 32'h184, 0);               // R9 clean victim, no push
    access(1, 0, 2'd2, 32'h024, 32'hCAFE_F00D);
    access(0, 1, 2'd2, 32'h024, 0);               // R10 read hit on dirty line, other mode
    do_inval();
    access(0, 0, 2'd2, 32'h024, 0);               // R11 dirty data dropped
    access(0, 0, 2'd2, 32'h184, 0);

    stall_on = 1;
    r = 32'hC0FF_EE01;
    for (int n = 0; n < 400; n++) begin
      logic [1:0]  sz;
      logic [31:0] a;
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      sz = (r[1:0] == 2'd3) ? 2'd2 : r[1:0];
      a  = {22'd0, r[11:4], (sz == 2'd0) ? r[3:2] : (sz == 2'd1) ? {r[3], 1'b0} : 2'b00};
      if (r[31:26] == 6'd0) do_inval();
      else access(r[24], r[25], sz, a, {r[7:0], r[31:8]});
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule